// File: doc/BRIEF.md
# Quadrature Phase-Slip Counter

This block keeps a running tally of the cycle slips between a reference carrier and a local oscillator. It takes the squared outputs of a quadrature mixer: an in-phase bit, a quadrature bit, and a second copy of the in-phase bit that reaches the block slightly later. All of these inputs arrive asynchronously to the system clock.

Every transition of the late in-phase copy is one count event. The exclusive-OR of the in-phase and quadrature bits decides whether the event adds one to or removes one from an 8-bit wrapping position register. A polarity pin can invert that direction. The late copy is arranged so that the direction is already stable when its edge arrives, which gives exactly one count for each slip.

While the carrier-valid input is low, events are dropped and the register holds its value. A host samples the position over a parallel bus that the block drives only while the host pulls its active-low enable low.

Top module: `phase_slip_counter`

## Requirements
- R1: The position register is 8 bits wide. It changes by exactly +1 or -1 for each accepted count event and is otherwise unchanged.
- R2: A count event is produced on both the rising and the falling transition of the delayed in-phase input.
- R3: With `pol_inv` low, the direction is `i_in XOR q_in`. A value of 1 counts up and 0 counts down. A full rotation of (I,Q) through 00,10,11,01 therefore adds 2, and a rotation through 00,01,11,10 subtracts 2.
- R4: With `pol_inv` high, the direction found in R3 is inverted.
- R5: The register wraps without any flag: up from 255 gives 0, and down from 0 gives 255.
- R6: While `carrier_ok` is low, count events are ignored and the register holds its value.
- R7: While `oe_n` is low, `cnt_bus` carries the position. While `oe_n` is high, `cnt_bus` is high-impedance. This path is combinational.
- R8: An event uses the direction that was present one system clock before the synchronized edge is seen. An I/Q change that reaches the synchronizers in the same cycle as a delayed-I edge does not affect that event.
- R9: Each asynchronous input goes through a two-flop synchronizer. A delayed-I change made between clock edges k-1 and k appears in the position after edge k+2, and is not yet visible after edge k+1.
- R10: A synchronous active-high `rst` clears the position to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| i_in | input | 1 | Squared in-phase mixer output (asynchronous) |
| q_in | input | 1 | Squared quadrature mixer output (asynchronous) |
| idly_in | input | 1 | Delayed in-phase copy used as the count clock (asynchronous) |
| pol_inv | input | 1 | Inverts the count direction when high |
| carrier_ok | input | 1 | Carrier-valid; low inhibits counting (asynchronous) |
| oe_n | input | 1 | Active-low bus output enable from the host |
| cnt_bus | inout | 8 | Position bus; driven while `oe_n` is low, high-impedance otherwise |

## Verification
The bench turns the I/Q pair in both directions, with and without inversion. It walks the register down through zero to 255 and back up through 255 to zero, so a design that saturates, or that counts only one edge of the delayed input, gives a wrong net count. It turns the pair while the carrier is invalid to catch a design that leaks counts. It changes I together with the delayed-I edge to catch a design that uses the fresh direction instead of the previous one. It measures the exact two-edge latency, which exposes a missing or extra synchronizer stage. It also lets a second driver share the bus while the enable is high, so that a design that never releases the bus is seen.

// File: rtl/psc_pkg.sv
package psc_pkg;

    localparam int CNT_W      = 8;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Bundle of asynchronous inputs carried through the synchronizer
    typedef struct packed {
        logic i;
        logic q;
        logic idly;
        logic cv;
    } psc_in_t;

    localparam int IN_W = $bits(psc_in_t);

    typedef struct packed {
        logic fire;
        dir_e dir;
    } cnt_evt_t;

    function automatic dir_e derive_dir(input logic i, input logic q, input logic inv);
        return dir_e'(i ^ q ^ inv);
    endfunction

endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
    parameter int W     = 4,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/psc_evt_gen.sv
module psc_evt_gen
    import psc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  psc_in_t  s_in,
    input  logic     pol_inv,
    output cnt_evt_t evt
);
    logic idly_prev;
    dir_e dir_prev;

    // Previous delayed-I level and previous-cycle direction
    always_ff @(posedge clk) begin
        if (rst) begin
            idly_prev <= 1'b0;
            dir_prev  <= DIR_DOWN;
        end else begin
            idly_prev <= s_in.idly;
            dir_prev  <= derive_dir(s_in.i, s_in.q, pol_inv);
        end
    end

    // Either edge of the delayed copy is one event
    always_comb begin
        evt.fire = s_in.idly ^ idly_prev;
        evt.dir  = dir_prev;
    end
endmodule

// File: rtl/psc_accum.sv
module psc_accum
    import psc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  cnt_evt_t     evt,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] nxt;

    always_comb begin
        nxt = count;
        if (en && evt.fire) begin
            if (evt.dir == DIR_UP) nxt = count + ONE;
            else                   nxt = count - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end
endmodule

// File: rtl/phase_slip_counter.sv
module phase_slip_counter
    import psc_pkg::*;
#(
    parameter int CW    = CNT_W,
    parameter int SYNCD = SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_in,
    input  logic          q_in,
    input  logic          idly_in,
    input  logic          pol_inv,
    input  logic          carrier_ok,
    input  logic          oe_n,
    inout  wire  [CW-1:0] cnt_bus
);
    psc_in_t     raw_in;
    psc_in_t     s_in;
    cnt_evt_t    evt;
    logic [CW-1:0] count_q;
    logic        evt_fire;
    logic        cv_s;

    always_comb begin
        raw_in.i    = i_in;
        raw_in.q    = q_in;
        raw_in.idly = idly_in;
        raw_in.cv   = carrier_ok;
    end

    psc_sync #(.W(IN_W), .DEPTH(SYNCD)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (s_in)
    );

    psc_evt_gen evt_i (
        .clk     (clk),
        .rst     (rst),
        .s_in    (s_in),
        .pol_inv (pol_inv),
        .evt     (evt)
    );

    assign evt_fire = evt.fire;
    assign cv_s     = s_in.cv;

    psc_accum #(.W(CW)) acc_i (
        .clk   (clk),
        .rst   (rst),
        .en    (cv_s),
        .evt   (evt),
        .count (count_q)
    );

    assign cnt_bus = oe_n ? {CW{1'bz}} : count_q;
endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         oe_n,
    input logic [W-1:0] bus,
    input logic [W-1:0] count,
    input logic         fire,
    input logic         en
);
    localparam logic [W-1:0] ONE = W'(1);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R1 R5
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && count != $past(count)) |->
            (count == $past(count) + ONE || count == $past(count) - ONE));

    // R1 R2
    no_event_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!fire) |=> $stable(count));

    // R6
    carrier_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> $stable(count));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0));

    // R7
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !oe_n) |-> (bus == count));
endmodule

bind phase_slip_counter psc_chk #(.W(CW)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .oe_n  (oe_n),
    .bus   (cnt_bus),
    .count (count_q),
    .fire  (evt_fire),
    .en    (cv_s)
);

// File: tb/phase_slip_counter_tb.sv
`timescale 1ns/1ps
module phase_slip_counter_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_in = 1'b0, q_in = 1'b0, idly_in = 1'b0;
    logic pol_inv = 1'b0, carrier_ok = 1'b1, oe_n = 1'b0;
    logic drv_en = 1'b0;
    wire  [7:0] bus;

    int n_chk  = 0;
    int n_fail = 0;
    int phase  = 0;   // 0:00 1:01 2:11 3:10 as (I,Q)

    always #2 clk = ~clk;

    assign bus = drv_en ? 8'hA5 : 8'hzz;

    phase_slip_counter dut_i (
        .clk(clk), .rst(rst), .i_in(i_in), .q_in(q_in), .idly_in(idly_in),
        .pol_inv(pol_inv), .carrier_ok(carrier_ok), .oe_n(oe_n), .cnt_bus(bus)
    );

    // {reverse, steps[3:0], pol, cv, expected[7:0]}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 4'd4,  1'b0, 1'b1, 8'd2},   // R3 up rotation, R2 both edges
        {1'b0, 4'd8,  1'b0, 1'b1, 8'd254}, // R3 down, R5 wrap below zero
        {1'b1, 4'd12, 1'b0, 1'b1, 8'd4},   // R5 wrap above 255
        {1'b1, 4'd4,  1'b1, 1'b1, 8'd2},   // R4 inverted up rotation
        {1'b0, 4'd4,  1'b1, 1'b1, 8'd4},   // R4 inverted down rotation
        {1'b1, 4'd8,  1'b0, 1'b0, 8'd4},   // R6 carrier invalid
        {1'b0, 4'd2,  1'b0, 1'b1, 8'd3},   // R1 half rotation
        {1'b1, 4'd2,  1'b0, 1'b1, 8'd4}    // R1 half rotation back
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_phase(input int p);
        phase = p;
        i_in  = (p == 2 || p == 3);
        q_in  = (p == 1 || p == 2);
    endtask

    // One quarter step: move I/Q, then let the delayed copy follow
    task automatic quarter(input logic rev);
        set_phase(rev ? (phase + 3) % 4 : (phase + 1) % 4);
        wait_clk(4);
        idly_in = i_in;
        wait_clk(5);
    endtask

    initial begin
        wait_clk(3);
        rst = 1'b0;
        wait_clk(1);
        chk("R10 reset state", bus, 8'd0);

        for (int v = 0; v < NV; v++) begin
            pol_inv    = VEC[v][9];
            carrier_ok = VEC[v][8];
            wait_clk(4);
            for (int s = 0; s < int'(VEC[v][13:10]); s++) quarter(VEC[v][14]);
            carrier_ok = 1'b1;
            pol_inv    = 1'b0;
            wait_clk(4);
            chk($sformatf("R1-vector %0d (R2 R3 R4 R5 R6)", v), bus, VEC[v][7:0]);
        end

        // R8: I changes together with the delayed edge; old direction (down) applies
        i_in = 1'b1; idly_in = 1'b1;
        wait_clk(6);
        chk("R8 stale direction", bus, 8'd3);
        i_in = 1'b0;
        wait_clk(4);
        idly_in = 1'b0;
        wait_clk(5);
        chk("R8 restore", bus, 8'd2);

        // R9: latency of exactly two edges after the one that first samples
        idly_in = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 not yet visible", bus, 8'd2);
        @(posedge clk); @(negedge clk);
        chk("R9 visible", bus, 8'd1);
        idly_in = 1'b0;
        wait_clk(5);
        chk("R9 second edge", bus, 8'd0);

        // R7: released bus reads the other driver
        oe_n = 1'b1; drv_en = 1'b1;
        #1;
        chk("R7 high impedance", bus, 8'hA5);
        drv_en = 1'b0; oe_n = 1'b0;
        #1;
        chk("R7 driven", bus, 8'd0);

        // R10: synchronous reset from a nonzero value
        for (int s = 0; s < 4; s++) quarter(1'b1);
        chk("R10 pre-reset", bus, 8'd2);
        rst = 1'b1;
        wait_clk(1);
        rst = 1'b0;
        wait_clk(1);
        chk("R10 cleared", bus, 8'd0);

        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end
endmodule